// File: doc/BRIEF.md
# Pipelined Decimal Floating-Point Adder

This block adds two signed decimal floating-point numbers at a rate of one pair per clock. Each operand has a sign bit, a two's-complement exponent and a mantissa of `NDIG` packed BCD digits. The mantissa is read as the fraction 0.d1d2…dn, with d1 in the most significant nibble, and the number's value is that fraction times ten to the exponent. An operand whose mantissa digits are all zero is the value zero, whatever its sign and exponent. Every nonzero operand is expected to be normalized, that is, d1 is nonzero.

The work is split across four registered stages:
1. The first stage compares the exponents and picks the operand with the larger one.
2. The second stage shifts the smaller operand right by whole digits.
3. The third stage adds or subtracts the mantissas in BCD.
4. The fourth stage normalizes the result back into the range from 0.1 up to (but not including) 1.

Every stage ends in a register. Operands that arrive on consecutive cycles therefore move through the block without disturbing one another.

Inside the block the mantissa carries one guard digit below the last visible digit. Digits shifted past that guard digit are lost, and the guard digit itself is dropped when the result is written out. No rounding is done. A caller presents operands with `in_valid` and collects results with `out_valid`, exactly four cycles later.

Top module: `dfp_pipe_adder`

## Requirements
- R1: A result appears with `out_valid` high exactly 4 clock cycles after the cycle in which `in_valid` was high. `out_valid` is low in every other cycle. Pairs issued on back-to-back cycles each produce their own correct result, at a rate of one per cycle.
- R2: Field encodings are as follows.
  - Mantissa: digit k (k = 1 is the most significant) sits in bits [4·(NDIG−k)+3 : 4·(NDIG−k)]. Every output digit is in the range 0..9.
  - Exponent: two's complement of width `EXP_W`.
  - Sign: 1 means negative.
  - A nonzero result always has a nonzero leading digit.
- R3: When the exponents differ, the operand with the smaller exponent is shifted right by one digit for each unit of difference. The result then starts from the larger exponent. When the exponents are equal, no shift takes place.
- R4: When both signs are equal, the magnitudes are added and the result takes that common sign.
- R5: When the signs differ, the smaller aligned magnitude is subtracted from the larger one. The result takes the sign of the operand with the larger aligned magnitude.
- R6: A magnitude sum of 1 or more is shifted right one digit and the exponent is raised by one. For example, 0.9700×10^2 plus 0.8100×10^1 gives 0.1051×10^3.
- R7: A nonzero result below 0.1 is shifted left until its leading digit is nonzero. The exponent is lowered by the number of digits shifted.
- R8: Exactly one guard digit below the last mantissa digit takes part in the add, subtract and normalize steps. Digits shifted out beyond it are discarded, and the guard digit is dropped at the output, with no rounding.
- R9: When the exponent difference is `NDIG` or more, the smaller operand adds nothing and the result equals the larger operand.
- R10: When exactly one operand is zero, the result is the other operand with its sign, exponent and mantissa unchanged.
- R11: A zero result is output with mantissa 0, exponent 0, sign 0 and `out_zero` high. `out_zero` is low for every nonzero result.
- R12: While reset is asserted, and in the first cycles after it is released, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EXP_W | Exponent of operand A |
| a_mant | input | 4·NDIG | BCD mantissa of operand A |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Exponent of operand B |
| b_mant | input | 4·NDIG | BCD mantissa of operand B |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | EXP_W | Exponent of the result |
| out_mant | output | 4·NDIG | Normalized BCD mantissa of the result |
| out_zero | output | 1 | Result is zero |

## Verification
The bench targets a set of specific corner cases.
- A sum that carries into a new leading digit: a design that misses it shows a leading digit larger than 9, or the exponent fails to move.
- Near-cancelling subtractions that need up to four digits of left shift: a wrong leading-zero count leaves the exponent off by the shift error.
- Operands whose sign order and size order disagree: a design that takes the sign from the wrong operand flips the result's sign.
- Truncation cases where the guard digit survives into the result after a left shift: a design without the guard digit, or one that rounds, differs in the last digit.
- Exponent gaps at and beyond the mantissa width, zero operands and exact cancellation: here an error shows up as a stray low-order digit, a changed exponent on a pass-through, or a zero that keeps a nonzero exponent or sign.
- A long back-to-back random burst: an overwritten stage register would pair the wrong operands.

// File: rtl/dfp_pkg.sv
package dfp_pkg;

  // What the normalize stage does to a raw sum
  typedef enum logic [1:0] {
    NORM_KEEP  = 2'd0,
    NORM_RIGHT = 2'd1,
    NORM_LEFT  = 2'd2,
    NORM_ZERO  = 2'd3
  } norm_act_e;

  // One BCD digit add: returns {carry_out, digit}
  function automatic logic [4:0] bcd_add_digit(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       cin);
    logic [4:0] s;
    s = {1'b0, x} + {1'b0, y} + {4'b0000, cin};
    if (s > 5'd9) return {1'b1, 4'(s - 5'd10)};
    else          return {1'b0, s[3:0]};
  endfunction

  // One BCD digit subtract x - y - bin: returns {borrow_out, digit}
  function automatic logic [4:0] bcd_sub_digit(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       bin);
    logic [4:0] t;
    t = {1'b0, x} - {1'b0, y} - {4'b0000, bin};
    if (t[4]) return {1'b1, 4'(t + 5'd10)};
    else      return {1'b0, t[3:0]};
  endfunction

endpackage

// File: rtl/dfp_cmp_stage.sv
module dfp_cmp_stage #(
  parameter int NDIG  = 4,
  parameter int EXP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     a_sign,
  input  logic [EXP_W-1:0]         a_exp,
  input  logic [4*NDIG-1:0]        a_mant,
  input  logic                     b_sign,
  input  logic [EXP_W-1:0]         b_exp,
  input  logic [4*NDIG-1:0]        b_mant,
  output logic                     s1_valid,
  output logic                     s1_big_sign,
  output logic [EXP_W-1:0]         s1_big_exp,
  output logic [4*NDIG-1:0]        s1_big_mant,
  output logic                     s1_small_sign,
  output logic [4*NDIG-1:0]        s1_small_mant,
  output logic [$clog2(NDIG+1)-1:0] s1_shamt
);
  localparam int MW   = 4 * NDIG;
  localparam int SH_W = $clog2(NDIG + 1);

  logic                    a_zero, b_zero, take_b;
  logic signed [EXP_W:0]   ediff;
  logic [EXP_W:0]          emag;
  logic                    big_sign_c, small_sign_c;
  logic [EXP_W-1:0]        big_exp_c, small_exp_c;
  logic [MW-1:0]           big_mant_c, small_mant_c;
  logic [SH_W-1:0]         shamt_c;

  assign a_zero = (a_mant == '0);
  assign b_zero = (b_mant == '0);
  assign ediff  = $signed({a_exp[EXP_W-1], a_exp}) - $signed({b_exp[EXP_W-1], b_exp});
  assign emag   = ediff[EXP_W] ? $unsigned(-ediff) : $unsigned(ediff);

  // A zero operand always becomes the small one; otherwise the smaller exponent does
  assign take_b = a_zero | (!b_zero & ediff[EXP_W]);

  assign big_sign_c   = take_b ? b_sign : a_sign;
  assign big_exp_c    = take_b ? b_exp  : a_exp;
  assign big_mant_c   = take_b ? b_mant : a_mant;
  assign small_sign_c = take_b ? a_sign : b_sign;
  assign small_exp_c  = take_b ? a_exp  : b_exp;
  assign small_mant_c = take_b ? a_mant : b_mant;

  always_comb begin
    if (small_mant_c == '0)
      shamt_c = '0;
    else if (emag >= (EXP_W+1)'(NDIG))
      shamt_c = SH_W'(NDIG);
    else
      shamt_c = emag[SH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_big_sign   <= big_sign_c;
      s1_big_exp    <= big_exp_c;
      s1_big_mant   <= big_mant_c;
      s1_small_sign <= small_sign_c;
      s1_small_mant <= small_mant_c;
      s1_shamt      <= shamt_c;
    end
  end

  // R3
  exp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_zero && !b_zero) |-> ($signed(big_exp_c) >= $signed(small_exp_c)));

  // R10
  zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && b_zero && !a_zero) |=>
      (s1_small_mant == '0 && s1_big_mant == $past(a_mant) && s1_big_exp == $past(a_exp)));

endmodule

// File: rtl/dfp_align_stage.sv
module dfp_align_stage #(
  parameter int NDIG  = 4,
  parameter int EXP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      big_sign,
  input  logic [EXP_W-1:0]          big_exp,
  input  logic [4*NDIG-1:0]         big_mant,
  input  logic                      small_sign,
  input  logic [4*NDIG-1:0]         small_mant,
  input  logic [$clog2(NDIG+1)-1:0] shamt,
  output logic                      s2_valid,
  output logic                      s2_big_sign,
  output logic                      s2_small_sign,
  output logic [EXP_W-1:0]          s2_exp,
  output logic [4*(NDIG+1)-1:0]     s2_big_ext,
  output logic [4*(NDIG+1)-1:0]     s2_small_ext
);
  localparam int XW   = 4 * (NDIG + 1);
  localparam int SH_W = $clog2(NDIG + 1);

  logic            too_far;
  logic [SH_W+1:0] bit_shift;
  logic [XW-1:0]   small_ext_c;

  assign too_far     = (shamt >= SH_W'(NDIG));
  assign bit_shift   = {shamt, 2'b00};
  // Guard digit appended below the visible digits, then shifted right by whole digits
  assign small_ext_c = too_far ? '0 : ({small_mant, 4'h0} >> bit_shift);

  always_ff @(posedge clk) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s2_big_sign   <= big_sign;
      s2_small_sign <= small_sign;
      s2_exp        <= big_exp;
      s2_big_ext    <= {big_mant, 4'h0};
      s2_small_ext  <= small_ext_c;
    end
  end

  // R9
  far_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shamt >= SH_W'(NDIG)) |=> (s2_small_ext == '0));

  // R3
  no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shamt == '0) |=> (s2_small_ext == {$past(small_mant), 4'h0}));

endmodule

// File: rtl/dfp_addsub_stage.sv
module dfp_addsub_stage
  import dfp_pkg::*;
#(
  parameter int NDIG  = 4,
  parameter int EXP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  big_sign,
  input  logic                  small_sign,
  input  logic [EXP_W-1:0]      in_exp,
  input  logic [4*(NDIG+1)-1:0] big_ext,
  input  logic [4*(NDIG+1)-1:0] small_ext,
  output logic                  s3_valid,
  output logic                  s3_sign,
  output logic [EXP_W-1:0]      s3_exp,
  output logic [4*(NDIG+2)-1:0] s3_sum
);
  localparam int XW = 4 * (NDIG + 1);
  localparam int SW = 4 * (NDIG + 2);
  localparam int ND = NDIG + 1;

  logic          eff_sub, big_ge;
  logic [XW-1:0] minuend, subtrahend, add_dig, sub_dig;
  logic [ND:0]   add_c, sub_b;
  logic          sub_borrow_out;
  logic [SW-1:0] res_c;
  logic          res_sign_c;

  assign eff_sub    = big_sign ^ small_sign;
  assign big_ge     = (big_ext >= small_ext);  // packed BCD keeps numeric order
  assign minuend    = big_ge ? big_ext   : small_ext;
  assign subtrahend = big_ge ? small_ext : big_ext;

  assign add_c[0] = 1'b0;
  assign sub_b[0] = 1'b0;

  for (genvar i = 0; i < ND; i++) begin : g_digit
    assign {add_c[i+1], add_dig[4*i +: 4]} =
      bcd_add_digit(big_ext[4*i +: 4], small_ext[4*i +: 4], add_c[i]);
    assign {sub_b[i+1], sub_dig[4*i +: 4]} =
      bcd_sub_digit(minuend[4*i +: 4], subtrahend[4*i +: 4], sub_b[i]);
  end

  assign sub_borrow_out = sub_b[ND];
  assign res_c      = eff_sub ? {4'h0, sub_dig} : {3'b000, add_c[ND], add_dig};
  assign res_sign_c = (eff_sub && !big_ge) ? small_sign : big_sign;

  always_ff @(posedge clk) begin
    if (!rst_n) s3_valid <= 1'b0;
    else        s3_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s3_sign <= res_sign_c;
      s3_exp  <= in_exp;
      s3_sum  <= res_c;
    end
  end

  // R5
  sub_no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_sub) |-> !sub_borrow_out);

  // R6
  carry_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s3_valid |-> (s3_sum[SW-1 -: 4] <= 4'd1));

  // R4
  add_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !eff_sub) |=> (s3_sign == $past(big_sign)));

endmodule

// File: rtl/dfp_norm_stage.sv
module dfp_norm_stage
  import dfp_pkg::*;
#(
  parameter int NDIG  = 4,
  parameter int EXP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sign,
  input  logic [EXP_W-1:0]      in_exp,
  input  logic [4*(NDIG+2)-1:0] in_sum,
  output logic                  out_valid,
  output logic                  out_sign,
  output logic [EXP_W-1:0]      out_exp,
  output logic [4*NDIG-1:0]     out_mant,
  output logic                  out_zero
);
  localparam int MW   = 4 * NDIG;
  localparam int XW   = 4 * (NDIG + 1);
  localparam int SW   = 4 * (NDIG + 2);
  localparam int LZ_W = $clog2(NDIG + 2);

  logic            has_carry, is_zero;
  logic [XW-1:0]   low_ext, left_ext;
  logic [LZ_W-1:0] lead_zeros;
  logic [LZ_W+1:0] left_bits;
  norm_act_e       act;
  logic [MW-1:0]   mant_c;
  logic [EXP_W-1:0] exp_c;

  assign has_carry = (in_sum[SW-1 -: 4] != 4'h0);
  assign is_zero   = (in_sum == '0);
  assign low_ext   = in_sum[XW-1:0];

  // Count zero digits from the top of the guarded mantissa
  always_comb begin
    logic found;
    found      = 1'b0;
    lead_zeros = '0;
    for (int i = NDIG; i >= 0; i--) begin
      if (!found) begin
        if (low_ext[4*i +: 4] == 4'h0) lead_zeros = lead_zeros + 1'b1;
        else                           found = 1'b1;
      end
    end
  end

  assign left_bits = {lead_zeros, 2'b00};
  assign left_ext  = low_ext << left_bits;

  always_comb begin
    if (is_zero)              act = NORM_ZERO;
    else if (has_carry)       act = NORM_RIGHT;
    else if (lead_zeros != 0) act = NORM_LEFT;
    else                      act = NORM_KEEP;
  end

  always_comb begin
    unique case (act)
      NORM_ZERO: begin
        mant_c = '0;
        exp_c  = '0;
      end
      NORM_RIGHT: begin
        mant_c = in_sum[SW-1 -: MW];
        exp_c  = in_exp + EXP_W'(1);
      end
      NORM_LEFT: begin
        mant_c = left_ext[XW-1 -: MW];
        exp_c  = in_exp - EXP_W'(lead_zeros);
      end
      default: begin
        mant_c = low_ext[XW-1 -: MW];
        exp_c  = in_exp;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_sign <= (act == NORM_ZERO) ? 1'b0 : in_sign;
      out_exp  <= exp_c;
      out_mant <= mant_c;
      out_zero <= (act == NORM_ZERO);
    end
  end

  // R2
  lead_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero) |-> (out_mant[MW-1 -: 4] != 4'h0));

  // R11
  zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_mant == '0 && out_exp == '0 && !out_sign));

  // R6
  right_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && act == NORM_RIGHT) |=> (out_exp == $past(in_exp) + EXP_W'(1)));

  for (genvar d = 0; d < NDIG; d++) begin : g_dchk
    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_mant[4*d +: 4] <= 4'd9));
  end

endmodule

// File: rtl/dfp_pipe_adder.sv
module dfp_pipe_adder #(
  parameter int NDIG  = 4,
  parameter int EXP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [4*NDIG-1:0] a_mant,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [4*NDIG-1:0] b_mant,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [4*NDIG-1:0] out_mant,
  output logic              out_zero
);
  localparam int MW   = 4 * NDIG;
  localparam int XW   = 4 * (NDIG + 1);
  localparam int SW   = 4 * (NDIG + 2);
  localparam int SH_W = $clog2(NDIG + 1);

  // Stage 1 -> 2
  logic             s1_valid, s1_big_sign, s1_small_sign;
  logic [EXP_W-1:0] s1_big_exp;
  logic [MW-1:0]    s1_big_mant, s1_small_mant;
  logic [SH_W-1:0]  s1_shamt;
  // Stage 2 -> 3
  logic             s2_valid, s2_big_sign, s2_small_sign;
  logic [EXP_W-1:0] s2_exp;
  logic [XW-1:0]    s2_big_ext, s2_small_ext;
  // Stage 3 -> 4
  logic             s3_valid, s3_sign;
  logic [EXP_W-1:0] s3_exp;
  logic [SW-1:0]    s3_sum;

  dfp_cmp_stage #(.NDIG(NDIG), .EXP_W(EXP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .s1_valid(s1_valid), .s1_big_sign(s1_big_sign), .s1_big_exp(s1_big_exp),
    .s1_big_mant(s1_big_mant), .s1_small_sign(s1_small_sign),
    .s1_small_mant(s1_small_mant), .s1_shamt(s1_shamt)
  );

  dfp_align_stage #(.NDIG(NDIG), .EXP_W(EXP_W)) u_align (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid),
    .big_sign(s1_big_sign), .big_exp(s1_big_exp), .big_mant(s1_big_mant),
    .small_sign(s1_small_sign), .small_mant(s1_small_mant), .shamt(s1_shamt),
    .s2_valid(s2_valid), .s2_big_sign(s2_big_sign), .s2_small_sign(s2_small_sign),
    .s2_exp(s2_exp), .s2_big_ext(s2_big_ext), .s2_small_ext(s2_small_ext)
  );

  dfp_addsub_stage #(.NDIG(NDIG), .EXP_W(EXP_W)) u_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(s2_valid),
    .big_sign(s2_big_sign), .small_sign(s2_small_sign), .in_exp(s2_exp),
    .big_ext(s2_big_ext), .small_ext(s2_small_ext),
    .s3_valid(s3_valid), .s3_sign(s3_sign), .s3_exp(s3_exp), .s3_sum(s3_sum)
  );

  dfp_norm_stage #(.NDIG(NDIG), .EXP_W(EXP_W)) u_norm (
    .clk(clk), .rst_n(rst_n), .in_valid(s3_valid),
    .in_sign(s3_sign), .in_exp(s3_exp), .in_sum(s3_sum),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_mant(out_mant), .out_zero(out_zero)
  );

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid, 3));

endmodule

// File: tb/dfp_pipe_adder_bench.sv
module dfp_pipe_adder_bench;
  localparam int NDIG  = 4;
  localparam int EXP_W = 8;
  localparam int MW    = 4 * NDIG;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              a_sign = 1'b0, b_sign = 1'b0;
  logic [EXP_W-1:0]  a_exp = '0, b_exp = '0;
  logic [MW-1:0]     a_mant = '0, b_mant = '0;
  logic              out_valid, out_sign, out_zero;
  logic [EXP_W-1:0]  out_exp;
  logic [MW-1:0]     out_mant;

  always #5 clk = ~clk;

  dfp_pipe_adder #(.NDIG(NDIG), .EXP_W(EXP_W)) u_dfp_pipe_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_mant(out_mant), .out_zero(out_zero)
  );

  typedef struct {
    int    due;
    bit    s;
    int    e;
    int    m;
    bit    z;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    errors = 0;
  int    edge_n = 0;
  string cur_tag = "R1";

  function automatic int pow10(input int n);
    int r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  function automatic logic [MW-1:0] to_bcd(input int v);
    logic [MW-1:0] r = '0;
    int t = v;
    for (int i = 0; i < NDIG; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int from_bcd(input logic [MW-1:0] v);
    int r = 0;
    for (int i = NDIG - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  // Behavioural model: integers with one guard digit
  function automatic exp_t model(input bit sa, input int ea, input int ma,
                                 input bit sb, input int eb, input int mb);
    exp_t o;
    int bx, sx, r, e, d;
    bit bs, ss;
    o.due = 0; o.tag = ""; o.s = 0; o.e = 0; o.m = 0; o.z = 0;
    if (ma == 0 && mb == 0) begin o.z = 1; return o; end
    if (ma == 0) begin o.s = sb; o.e = eb; o.m = mb; return o; end
    if (mb == 0) begin o.s = sa; o.e = ea; o.m = ma; return o; end
    if (ea >= eb) begin
      bs = sa; ss = sb; e = ea; d = ea - eb; bx = ma * 10; sx = mb * 10;
    end else begin
      bs = sb; ss = sa; e = eb; d = eb - ea; bx = mb * 10; sx = ma * 10;
    end
    sx = (d >= NDIG) ? 0 : sx / pow10(d);
    if (bs == ss)      begin r = bx + sx; o.s = bs; end
    else if (bx >= sx) begin r = bx - sx; o.s = bs; end
    else               begin r = sx - bx; o.s = ss; end
    if (r == 0) begin o.s = 0; o.z = 1; return o; end
    if (r >= pow10(NDIG + 1)) begin r = r / 10; e = e + 1; end
    else while (r < pow10(NDIG)) begin r = r * 10; e = e - 1; end
    o.e = e; o.m = r / 10;
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic compare_outputs();
    exp_t x;
    if (q.size() > 0 && q[0].due == edge_n) begin
      x = q.pop_front();
      chk(out_valid == 1'b1, "R1", "out_valid", int'(out_valid), 1);
      chk(out_zero == x.z, x.tag, "out_zero", int'(out_zero), int'(x.z));
      chk(out_sign == x.s, x.tag, "out_sign", int'(out_sign), int'(x.s));
      chk(int'($signed(out_exp)) == x.e, x.tag, "out_exp", int'($signed(out_exp)), x.e);
      chk(from_bcd(out_mant) == x.m, x.tag, "out_mant", from_bcd(out_mant), x.m);
      for (int d = 0; d < NDIG; d++)
        chk(out_mant[4*d +: 4] <= 4'd9, "R2", "digit range", int'(out_mant[4*d +: 4]), 9);
      if (!x.z)
        chk(out_mant[MW-1 -: 4] != 4'h0, "R2", "leading digit", int'(out_mant[MW-1 -: 4]), 1);
    end else begin
      chk(out_valid == 1'b0, rst_n ? "R1" : "R12", "idle out_valid", int'(out_valid), 0);
    end
  endtask

  // One clock: push the expectation at the sampling edge, compare at the next falling edge
  task automatic tick();
    exp_t x;
    @(posedge clk);
    edge_n++;
    if (in_valid && rst_n) begin
      x = model(a_sign, int'($signed(a_exp)), from_bcd(a_mant),
                b_sign, int'($signed(b_exp)), from_bcd(b_mant));
      x.due = edge_n + 3;
      x.tag = cur_tag;
      q.push_back(x);
    end
    @(negedge clk);
    compare_outputs();
  endtask

  task automatic op(input string tag, input bit sa, input int ea, input int ma,
                    input bit sb, input int eb, input int mb);
    cur_tag  = tag;
    in_valid = 1'b1;
    a_sign = sa; a_exp = EXP_W'(ea); a_mant = to_bcd(ma);
    b_sign = sb; b_exp = EXP_W'(eb); b_mant = to_bcd(mb);
    tick();
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", edge_n, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12: outputs idle through reset
    in_valid = 1'b1;
    a_mant = to_bcd(5000); b_mant = to_bcd(5000);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); edge_n++; @(negedge clk);
      chk(out_valid == 1'b0, "R12", "out_valid in reset", int'(out_valid), 0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(4);

    // R6: carry out of the top digit
    op("R6", 0, 2, 9700, 0, 1, 8100);
    idle(5);
    // R4: same sign, with and without carry
    op("R4", 0, 3, 1200, 0, 3, 3400);
    op("R4", 1, 1, 1234, 1, 0, 2000);
    op("R4", 1, -2, 9999, 1, -2, 9999);
    // R3: B larger exponent, equal exponents
    op("R3", 0, 0, 5000, 0, 2, 1000);
    op("R3", 0, -3, 4444, 0, -3, 1111);
    // R5: differing signs, both orders of size
    op("R5", 0, 1, 5000, 1, 1, 2000);
    op("R5", 1, 0, 7000, 0, 0, 2000);
    op("R5", 0, 0, 2000, 1, 0, 7000);
    op("R5", 1, 0, 1500, 0, 1, 1200);
    // R7: deep left shifts
    op("R7", 0, 1, 1000, 1, 0, 9999);
    op("R7", 0, 2, 5432, 1, 2, 5431);
    op("R7", 1, 0, 1234, 0, 0, 1200);
    // R8: truncation and guard digit
    op("R8", 0, 0, 1234, 0, -2, 5678);
    op("R8", 0, 1, 1000, 1, -1, 1239);
    op("R8", 0, 0, 9999, 0, -3, 9999);
    // R9: exponent gap at and past the mantissa width
    op("R9", 0, 4, 1000, 1, 0, 9999);
    op("R9", 0, -5, 4321, 0, 5, 9000);
    op("R9", 1, 3, 1000, 0, 0, 9999);
    // R10: one operand zero
    op("R10", 0, 9, 0, 1, -7, 4567);
    op("R10", 1, 20, 3141, 1, -30, 0);
    // R11: zero results
    op("R11", 0, 2, 3333, 1, 2, 3333);
    op("R11", 1, 5, 0, 1, -6, 0);
    op("R11", 1, 0, 1000, 0, 1, 1000);
    idle(6);

    // R1: back-to-back random burst, then a gapped stream
    for (int i = 0; i < 120; i++) begin
      int ma, mb;
      ma = ($urandom_range(9) == 0) ? 0 : 1000 + int'($urandom_range(8999));
      mb = ($urandom_range(9) == 0) ? 0 : 1000 + int'($urandom_range(8999));
      op("R1", 1'($urandom_range(1)), int'($urandom_range(12)) - 6, ma,
               1'($urandom_range(1)), int'($urandom_range(12)) - 6, mb);
    end
    for (int i = 0; i < 80; i++) begin
      if ($urandom_range(2) == 0) idle(1);
      else op("R1", 1'($urandom_range(1)), int'($urandom_range(4)) - 2,
                    1000 + int'($urandom_range(8999)),
                    1'($urandom_range(1)), int'($urandom_range(4)) - 2,
                    1000 + int'($urandom_range(8999)));
    end
    idle(8);
    chk(q.size() == 0, "R1", "results outstanding", q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule